// File: doc/BRIEF.md
# Conditional Branch Resolution Unit

This unit settles the outcome of a branch instruction once its kind is known. It takes a 4-bit branch kind, the four condition flags, a signed 8-bit word offset, the address of the next sequential instruction and, for the loop form, a loop register value and an unsigned 6-bit backward word offset. One clock later it presents whether the branch is taken and the address that execution continues from. For the loop form it also presents the decremented register value with a write strobe.

The unit covers four groups of branch. The first is an unconditional branch. The second tests a single flag, set or clear. The third compares signed values against zero using N, V and Z. The fourth compares unsigned values using C and Z. A decrement-and-loop form completes the set. Offsets count 16-bit words, so they are doubled before they are added to the address. The unit does not decode other instructions and does not flush a pipeline.

Top module: `br_resolve`

## Requirements
- R1: All outputs are registered and reflect the inputs present at the previous rising clock edge. Kind code 0 (always) with `br_en_i` high is taken regardless of the flags.
- R2: `cc_i` carries N in bit 3, Z in bit 2, V in bit 1 and C in bit 0. Each of the following codes branches when its flag matches: 1 when Z is 0, 2 when Z is 1, 3 when N is 0, 4 when N is 1, 5 when V is 0, 6 when V is 1, 7 when C is 0 (this also serves as unsigned higher-or-same), and 8 when C is 1 (this also serves as unsigned lower).
- R3: The signed codes compare against zero. Code 9 is taken when N equals V. Code 10 is taken when N differs from V. Code 11 is taken when Z is 0 and N equals V. Code 12 is taken when Z is 1 or N differs from V.
- R4: Code 13 (unsigned higher) is taken when C and Z are both 0. Code 14 (unsigned lower-or-same) is taken when C or Z is 1.
- R5: For codes 0 to 14, the target is `next_pc_i` plus twice the sign-extended `off_i`, modulo 2^16. The offset therefore spans -128 to +127 words.
- R6: Code 15 with `br_en_i` high writes `loop_reg_i` minus one, modulo 2^16, to `reg_val_o` and raises `reg_wr_o`. The write happens even when the result is zero. `cc_i` does not affect this result.
- R7: Code 15 is taken exactly when the decremented value is nonzero. Its target is `next_pc_i` minus twice the zero-extended `loop_off_i`, modulo 2^16.
- R8: When a branch is not taken, or when `br_en_i` is low, `pc_o` equals `next_pc_i`. When `br_en_i` is low, `taken_o` and `reg_wr_o` are 0. `reg_wr_o` rises only for code 15.
- R9: A clock edge with `rst_n` low clears `taken_o`, `reg_wr_o`, `pc_o` and `reg_val_o` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| br_en_i | input | 1 | A branch is being resolved this cycle |
| kind_i | input | 4 | Branch kind code |
| cc_i | input | 4 | Condition flags {N, Z, V, C} |
| off_i | input | 8 | Signed word offset for codes 0 to 14 |
| loop_off_i | input | 6 | Unsigned backward word offset for code 15 |
| next_pc_i | input | 16 | Address of the next sequential instruction |
| loop_reg_i | input | 16 | Loop register value before decrement |
| taken_o | output | 1 | Branch taken |
| pc_o | output | 16 | Address to continue from |
| reg_wr_o | output | 1 | Write strobe for the decremented loop register |
| reg_val_o | output | 16 | Decremented loop register value |

## Verification
The hardest cases to reach involve the loop form at its edges. A register value of 1 decrements to zero, so the unit must still write but must not branch. A value of 0 wraps around to all ones and does branch. The stimulus pairs these register values, together with 2, 3, 0x8000 and 0xFFFF, with every one of the 64 backward offsets. It also drives a next address near zero so that the backward target wraps below address zero. Forward targets are swept over all 256 offsets from a base near the top of the address space, and the condition codes are swept over all 16 flag patterns.

// File: rtl/br_resolve_pkg.sv
// Shared types for the branch resolution unit.
// Assumes a 4-bit kind code where 15 is the decrement-and-loop form.
package br_resolve_pkg;
    typedef enum logic [3:0] {
        BK_ALWAYS = 4'd0,
        BK_ZCLR   = 4'd1,
        BK_ZSET   = 4'd2,
        BK_NCLR   = 4'd3,
        BK_NSET   = 4'd4,
        BK_VCLR   = 4'd5,
        BK_VSET   = 4'd6,
        BK_CCLR   = 4'd7,
        BK_CSET   = 4'd8,
        BK_SGE    = 4'd9,
        BK_SLT    = 4'd10,
        BK_SGT    = 4'd11,
        BK_SLE    = 4'd12,
        BK_UHI    = 4'd13,
        BK_ULS    = 4'd14,
        BK_LOOP   = 4'd15
    } br_kind_e;

    typedef struct packed {
        logic n;
        logic z;
        logic v;
        logic c;
    } cc_t;
endpackage

// File: rtl/br_cond_eval.sv
// Evaluates the flag condition for branch kinds 0..14.
// Assumes the loop kind is decided elsewhere; it yields 0 here.
module br_cond_eval
    import br_resolve_pkg::*;
(
    input  br_kind_e kind_i,
    input  cc_t      cc_i,
    output logic     hit_o
);
    logic sgn_lt;
    logic uns_ls;

    // Derive the shared signed and unsigned terms.
    always_comb begin
        sgn_lt = cc_i.n ^ cc_i.v;
        uns_ls = cc_i.c | cc_i.z;
    end

    // Select the condition for the requested kind.
    always_comb begin
        unique case (kind_i)
            BK_ALWAYS: hit_o = 1'b1;
            BK_ZCLR:   hit_o = ~cc_i.z;
            BK_ZSET:   hit_o = cc_i.z;
            BK_NCLR:   hit_o = ~cc_i.n;
            BK_NSET:   hit_o = cc_i.n;
            BK_VCLR:   hit_o = ~cc_i.v;
            BK_VSET:   hit_o = cc_i.v;
            BK_CCLR:   hit_o = ~cc_i.c;
            BK_CSET:   hit_o = cc_i.c;
            BK_SGE:    hit_o = ~sgn_lt;
            BK_SLT:    hit_o = sgn_lt;
            BK_SGT:    hit_o = ~(cc_i.z | sgn_lt);
            BK_SLE:    hit_o = cc_i.z | sgn_lt;
            BK_UHI:    hit_o = ~uns_ls;
            BK_ULS:    hit_o = uns_ls;
            default:   hit_o = 1'b0;
        endcase
    end
endmodule

// File: rtl/br_target_gen.sv
// Computes the branch target from the next address and a word offset.
// Forward kinds use a signed offset; the loop kind subtracts an unsigned one.
// Assumes ADDR_W is wider than either offset plus one bit.
module br_target_gen #(
    parameter int ADDR_W = 16,
    parameter int OFF_W  = 8,
    parameter int LOFF_W = 6
) (
    input  logic [ADDR_W-1:0] next_pc_i,
    input  logic [OFF_W-1:0]  off_i,
    input  logic [LOFF_W-1:0] loop_off_i,
    input  logic              backward_i,
    output logic [ADDR_W-1:0] target_o
);
    localparam int SEXT_W = ADDR_W - OFF_W;
    localparam int ZEXT_W = ADDR_W - LOFF_W;

    logic [ADDR_W-1:0] fwd_words;
    logic [ADDR_W-1:0] back_words;
    logic [ADDR_W-1:0] addend;

    // Widen both offsets, convert words to bytes, pick one addend.
    always_comb begin
        fwd_words  = {{SEXT_W{off_i[OFF_W-1]}}, off_i};
        back_words = {{ZEXT_W{1'b0}}, loop_off_i};
        addend     = backward_i ? (~(back_words << 1) + ADDR_W'(1))
                                : (fwd_words << 1);
    end

    // A single adder serves both directions.
    always_comb begin
        target_o = next_pc_i + addend;
    end
endmodule

// File: rtl/br_loop_dec.sv
// Decrements the loop register and flags a nonzero result.
// Assumes wrap-around arithmetic modulo 2^DATA_W.
module br_loop_dec #(
    parameter int DATA_W = 16
) (
    input  logic [DATA_W-1:0] val_i,
    output logic [DATA_W-1:0] dec_o,
    output logic              nonzero_o
);
    // Subtract one and test the result for zero.
    always_comb begin
        dec_o     = val_i - DATA_W'(1);
        nonzero_o = |dec_o;
    end
endmodule

// File: rtl/br_resolve.sv
// Top of the branch resolution unit: decides taken, selects the next
// address and produces the loop register write, all registered once.
// Assumes the kind code arrives already decoded, with br_en_i qualifying it.
module br_resolve
    import br_resolve_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16,
    parameter int OFF_W  = 8,
    parameter int LOFF_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              br_en_i,
    input  logic [3:0]        kind_i,
    input  logic [3:0]        cc_i,
    input  logic [OFF_W-1:0]  off_i,
    input  logic [LOFF_W-1:0] loop_off_i,
    input  logic [ADDR_W-1:0] next_pc_i,
    input  logic [DATA_W-1:0] loop_reg_i,
    output logic              taken_o,
    output logic [ADDR_W-1:0] pc_o,
    output logic              reg_wr_o,
    output logic [DATA_W-1:0] reg_val_o
);
    br_kind_e          kind;
    cc_t               flags;
    logic              is_loop;
    logic              cond_hit;
    logic              loop_nz;
    logic [DATA_W-1:0] loop_dec;
    logic [ADDR_W-1:0] target;
    logic              taken_d;
    logic [ADDR_W-1:0] pc_d;
    logic              wr_d;

    // Type the raw inputs.
    always_comb begin
        kind    = br_kind_e'(kind_i);
        flags   = cc_t'(cc_i);
        is_loop = (kind == BK_LOOP);
    end

    br_cond_eval u_cond (
        .kind_i (kind),
        .cc_i   (flags),
        .hit_o  (cond_hit)
    );

    br_target_gen #(
        .ADDR_W (ADDR_W),
        .OFF_W  (OFF_W),
        .LOFF_W (LOFF_W)
    ) u_tgt (
        .next_pc_i  (next_pc_i),
        .off_i      (off_i),
        .loop_off_i (loop_off_i),
        .backward_i (is_loop),
        .target_o   (target)
    );

    br_loop_dec #(
        .DATA_W (DATA_W)
    ) u_dec (
        .val_i     (loop_reg_i),
        .dec_o     (loop_dec),
        .nonzero_o (loop_nz)
    );

    // Combine the decision and pick the continuation address.
    always_comb begin
        taken_d = br_en_i & (is_loop ? loop_nz : cond_hit);
        wr_d    = br_en_i & is_loop;
        pc_d    = taken_d ? target : next_pc_i;
    end

    // Register the results with a synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            taken_o   <= 1'b0;
            pc_o      <= '0;
            reg_wr_o  <= 1'b0;
            reg_val_o <= '0;
        end else begin
            taken_o   <= taken_d;
            pc_o      <= pc_d;
            reg_wr_o  <= wr_d;
            reg_val_o <= loop_dec;
        end
    end
endmodule

// File: rtl/br_resolve_chk.sv
// Checker for the branch resolution unit, bound to every instance.
// Assumes the 4-bit kind code with 0 = always and 15 = loop.
module br_resolve_chk #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              br_en_i,
    input logic [3:0]        kind_i,
    input logic [ADDR_W-1:0] next_pc_i,
    input logic [DATA_W-1:0] loop_reg_i,
    input logic              taken_o,
    input logic [ADDR_W-1:0] pc_o,
    input logic              reg_wr_o,
    input logic [DATA_W-1:0] reg_val_o
);
    a_r9_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> (!taken_o && !reg_wr_o));

    a_r8_write_only_loop: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && reg_wr_o) |-> ($past(br_en_i) && $past(kind_i) == 4'd15));

    a_r6_dec_value: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && reg_wr_o) |-> (reg_val_o == $past(loop_reg_i) - DATA_W'(1)));

    a_r7_loop_taken: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && reg_wr_o) |-> (taken_o == (reg_val_o != '0)));

    a_r8_fallthrough: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !taken_o) |-> (pc_o == $past(next_pc_i)));

    a_r1_always_taken: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(br_en_i) && $past(kind_i) == 4'd0) |-> taken_o);
endmodule

bind br_resolve br_resolve_chk #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .br_en_i    (br_en_i),
    .kind_i     (kind_i),
    .next_pc_i  (next_pc_i),
    .loop_reg_i (loop_reg_i),
    .taken_o    (taken_o),
    .pc_o       (pc_o),
    .reg_wr_o   (reg_wr_o),
    .reg_val_o  (reg_val_o)
);

// File: tb/br_resolve_tb_top.sv
module br_resolve_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        br_en_i = 1'b0;
    logic [3:0]  kind_i = '0;
    logic [3:0]  cc_i = '0;
    logic [7:0]  off_i = '0;
    logic [5:0]  loop_off_i = '0;
    logic [15:0] next_pc_i = '0;
    logic [15:0] loop_reg_i = '0;
    logic        taken_o;
    logic [15:0] pc_o;
    logic        reg_wr_o;
    logic [15:0] reg_val_o;

    int n_checks = 0;
    int n_errs = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    br_resolve dut_i (
        .clk(clk), .rst_n(rst_n), .br_en_i(br_en_i), .kind_i(kind_i),
        .cc_i(cc_i), .off_i(off_i), .loop_off_i(loop_off_i),
        .next_pc_i(next_pc_i), .loop_reg_i(loop_reg_i),
        .taken_o(taken_o), .pc_o(pc_o), .reg_wr_o(reg_wr_o), .reg_val_o(reg_val_o)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errs++;
            $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic en, input logic [3:0] k, input logic [3:0] f,
                         input logic [7:0] o, input logic [5:0] lo,
                         input logic [15:0] np, input logic [15:0] r);
        @(negedge clk);
        br_en_i = en; kind_i = k; cc_i = f; off_i = o;
        loop_off_i = lo; next_pc_i = np; loop_reg_i = r;
        @(posedge clk);
        #1;
    endtask

    function automatic bit exp_taken(input int k, input logic [3:0] f);
        bit n, z, v, c;
        n = f[3]; z = f[2]; v = f[1]; c = f[0];
        case (k)
            0:  return 1;
            1:  return z == 0;
            2:  return z == 1;
            3:  return n == 0;
            4:  return n == 1;
            5:  return v == 0;
            6:  return v == 1;
            7:  return c == 0;
            8:  return c == 1;
            9:  return n == v;
            10: return n != v;
            11: return (z == 0) && (n == v);
            12: return (z == 1) || (n != v);
            13: return (c == 0) && (z == 0);
            default: return (c == 1) || (z == 1);
        endcase
    endfunction

    function automatic string req_of(input int k);
        if (k == 0) return "R1";
        if (k <= 8) return "R2";
        if (k <= 12) return "R3";
        return "R4";
    endfunction

    function automatic logic [15:0] fwd_target(input logic [15:0] np, input logic [7:0] o);
        int d;
        d = int'($signed(o));
        return 16'(int'(np) + 2 * d);
    endfunction

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_errs++;
            n_checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
            $finish;
        end
    end

    initial begin
        logic [15:0] regs [6];
        regs[0] = 16'h0000; regs[1] = 16'h0001; regs[2] = 16'h0002;
        regs[3] = 16'h0003; regs[4] = 16'h8000; regs[5] = 16'hFFFF;

        // R9: reset clears every output.
        drive(1'b1, 4'd0, 4'hF, 8'h7F, 6'd5, 16'h1234, 16'h0005);
        drive(1'b1, 4'd15, 4'hF, 8'h7F, 6'd5, 16'h1234, 16'h0005);
        check("R9", "taken", 32'(taken_o), 32'd0);
        check("R9", "pc", 32'(pc_o), 32'd0);
        check("R9", "wr", 32'(reg_wr_o), 32'd0);
        check("R9", "val", 32'(reg_val_o), 32'd0);
        @(negedge clk); rst_n = 1'b1;

        // R1..R4: every non-loop kind against every flag pattern.
        for (int k = 0; k < 15; k++) begin
            for (int f = 0; f < 16; f++) begin
                bit t;
                t = exp_taken(k, 4'(f));
                drive(1'b1, 4'(k), 4'(f), 8'h05, 6'd3, 16'h1000, 16'h0009);
                check(req_of(k), "taken", 32'(taken_o), 32'(t));
                check(t ? "R5" : "R8", "pc", 32'(pc_o), 32'(t ? 16'h100A : 16'h1000));
                check("R8", "no write", 32'(reg_wr_o), 32'd0);
            end
        end

        // R5: all forward offsets from two bases, one wrapping past the top.
        for (int o = 0; o < 256; o++) begin
            drive(1'b1, 4'd0, 4'h0, 8'(o), 6'd0, 16'hFFF0, 16'h0);
            check("R5", "pc high base", 32'(pc_o), 32'(fwd_target(16'hFFF0, 8'(o))));
            drive(1'b1, 4'd0, 4'h5, 8'(o), 6'd0, 16'h0200, 16'h0);
            check("R5", "pc low base", 32'(pc_o), 32'(fwd_target(16'h0200, 8'(o))));
        end

        // R6/R7: loop form over edge register values and all backward offsets.
        for (int ri = 0; ri < 6; ri++) begin
            for (int lo = 0; lo < 64; lo++) begin
                logic [15:0] dec;
                logic [15:0] np;
                bit t;
                dec = regs[ri] - 16'd1;
                t = (dec != 16'd0);
                np = (lo[0]) ? 16'h0040 : 16'h4000;
                drive(1'b1, 4'd15, 4'(lo), 8'h80, 6'(lo), np, regs[ri]);
                check("R6", "write", 32'(reg_wr_o), 32'd1);
                check("R6", "value", 32'(reg_val_o), 32'(dec));
                check("R7", "taken", 32'(taken_o), 32'(t));
                check("R7", "pc", 32'(pc_o),
                      32'(t ? 16'(int'(np) - 2 * lo) : np));
            end
        end

        // R8: disabled resolution neither branches nor writes.
        drive(1'b0, 4'd0, 4'h0, 8'h10, 6'd1, 16'h2222, 16'h0005);
        check("R8", "idle taken", 32'(taken_o), 32'd0);
        check("R8", "idle pc", 32'(pc_o), 32'h2222);
        drive(1'b0, 4'd15, 4'h0, 8'h10, 6'd1, 16'h3333, 16'h0005);
        check("R8", "idle loop wr", 32'(reg_wr_o), 32'd0);
        check("R8", "idle loop taken", 32'(taken_o), 32'd0);
        check("R8", "idle loop pc", 32'(pc_o), 32'h3333);

        // R1: output holds until the next edge after an input change.
        drive(1'b1, 4'd0, 4'h0, 8'h01, 6'd0, 16'h0100, 16'h0);
        @(negedge clk);
        br_en_i = 1'b0; next_pc_i = 16'h0500;
        #2;
        check("R1", "latency hold", 32'(pc_o), 32'h0102);
        @(posedge clk); #1;
        check("R1", "latency update", 32'(pc_o), 32'h0500);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errs, n_checks);
        $finish;
    end
endmodule